// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache

This block sits between a processor load/store port and a word-wide memory port. It holds 64 sets of four 16-byte lines. A request carries a byte address and, for stores, a 32-bit word. The cache compares the tag against all four ways of the indexed set in parallel. A read hit completes in the next cycle. A miss picks a victim line, writes back whatever part of that line is dirty, fills the line from memory, and then completes the original request out of the refilled line.

The write policy is chosen for each request by a mode input. In write-back mode a store only updates the cache and marks that word dirty. In write-through mode a store updates the cache and also sends the word to memory, and it leaves no dirty mark. Dirty state is kept per 32-bit word, so an eviction moves only the words that really changed. Victims come from an 8-bit linear-feedback shift register, but an empty way is always taken first. A flush input invalidates the whole cache in one cycle.

Top module: `dcache_4way`

## Requirements
- R1: The address splits as tag = bits [31:10], set = bits [9:4], word-in-line = bits [3:2]. Bits [1:0] are ignored, so every access covers a whole 32-bit word. Two addresses with the same set and different tags are separate lines.
- R2: A read that hits raises `cpu_ready` exactly one cycle after the request is first presented, with `cpu_hit`=1 and the word on `cpu_rdata`.
- R3: On a miss, the lowest-numbered invalid way of the set is the victim if one exists; otherwise the victim is the random way. The fill issues four memory reads at line offsets 0, 4, 8 and 12, in that order. The request then completes with `cpu_hit`=0.
- R4: A write-back-mode store that hits makes no memory request and updates the cached word.
- R5: Evicting a line writes to memory only its dirty words, in ascending word order, and all of these writes come before the first fill read.
- R6: A write-through-mode store makes exactly one memory write, of that word at its word-aligned address, before `cpu_ready`. It leaves the word clean, so a later eviction of the line writes nothing.
- R7: In the idle state, `flush` clears every valid bit and every dirty bit in one cycle and takes priority over a request presented in the same cycle. The next access to any line misses.
- R8: A valid bit is set only when a fill completes and is cleared only by a flush.
- R9: The random way comes from an 8-bit maximal-length LFSR that is never zero and advances every clock, so repeated misses to a full set reach different ways.
- R10: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`. Each acknowledge moves one word.
- R11: `cpu_ready` is a one-cycle pulse, and no memory request is active while it is high. After reset `cpu_ready` and `mem_req` are low. The requester holds its request until `cpu_ready`.
- R12: Under any mix of modes, hits, misses and evictions, a read returns the value most recently stored to that word address. A word never stored returns the memory's content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back, sampled with the request |
| flush | input | 1 | Invalidate all lines (acted on when idle) |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request hit on its first lookup; valid with `cpu_ready` |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Transfer done, one cycle |

## Verification
A stale tag or a valid bit set in error shows up on the very next read of that line. It appears as `cpu_hit` with a one-cycle response carrying the wrong word, where a fill would have been expected. A lost or spurious dirty bit stays hidden until its line is evicted. It then appears as missing or extra memory writes, and a later miss on the same word returns an old value. A victim choice that ignores empty ways appears as an unexpected miss when four lines that fit in one set are read back. A stuck random source appears as a dirty line that is never evicted during a long run of conflicting misses.

// File: rtl/cache_pkg.sv
// Shared types for the data cache. Holds only the controller state encoding.
package cache_pkg;
    typedef enum logic [2:0] {
        S_IDLE,   // accept a request or a flush
        S_WB,     // send dirty words of the victim to memory
        S_FILL,   // read the new line, word by word
        S_REPLAY, // complete the request from the refilled line
        S_WT,     // write-through store to memory
        S_DONE    // one-cycle completion pulse
    } state_t;
endpackage

// File: rtl/cache_lfsr.sv
// Galois LFSR used as the random source for victim choice.
// Assumes TAPS describes a maximal-length polynomial for W bits; a seed of 1 keeps it nonzero.
module cache_lfsr #(
    parameter int W = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    // Shift every cycle and fold in the taps when the bit shifted out is set.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= W'(1);
        else        q <= (q >> 1) ^ (q[0] ? TAPS : '0);
    end
endmodule

// File: rtl/cache_tag_match.sv
// Parallel tag compare across all ways of one set.
// Assumes at most one valid way matches a tag; the lowest index wins if not.
module cache_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]       way_valid,
    input  logic [TAG_W-1:0]      tag,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == tag);
    end

    assign hit = |match;

    // Encode the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_victim.sv
// Victim way selection: the lowest invalid way, otherwise the supplied random way.
// Assumes rnd is already reduced to WAY_W bits.
module cache_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAY_W-1:0] rnd,
    output logic [WAY_W-1:0] way
);
    // Prefer an empty way, scanning so that the lowest index wins.
    always_comb begin
        way = rnd;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/dcache_4way.sv
// Set-associative data cache with a per-word dirty mask and a write policy chosen per request.
// It handles one miss at a time. The requester holds cpu_req until cpu_ready. Memory moves one
// word per mem_ack, and mem_ack comes only while mem_req is high. Flush discards dirty data.
module dcache_4way
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int WORDS  = 4,
    parameter int LFSR_W = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              wt_mode,
    input  logic              flush,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WORD_W = $clog2(WORDS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int OFF_W  = BYTE_W + WORD_W;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

    // Storage
    logic [DATA_W-1:0] data_q  [SETS][WAYS][WORDS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WORDS-1:0]  dirty_q [SETS][WAYS];

    // Control and request state
    state_t            state;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata, rdata_q;
    logic              rq_we, rq_wt, hit_q;
    logic [WORD_W-1:0] cnt;
    logic [WAY_W-1:0]  vway;
    logic [TAG_W-1:0]  vtag;
    logic [WORDS-1:0]  vdirty;

    // Lookup datapath
    logic [ADDR_W-1:0]     cur_addr;
    logic [SET_W-1:0]      cur_set;
    logic [TAG_W-1:0]      cur_tag;
    logic [WORD_W-1:0]     cur_word;
    logic [WAYS*TAG_W-1:0] way_tags;
    logic                  hit;
    logic [WAY_W-1:0]      hit_way, vic_way;
    logic [LFSR_W-1:0]     lfsr_q;
    logic [SETS*WAYS-1:0]  valid_flat;
    logic                  accept, act_go, act_we, act_wt;
    logic [DATA_W-1:0]     act_wdata;

    assign cur_addr = (state == S_IDLE) ? cpu_addr : rq_addr;
    assign cur_set  = cur_addr[OFF_W +: SET_W];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_word = cur_addr[BYTE_W +: WORD_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_tags
        assign way_tags[w*TAG_W +: TAG_W] = tag_q[cur_set][w];
    end
    for (genvar s = 0; s < SETS; s++) begin : g_valid
        assign valid_flat[s*WAYS +: WAYS] = valid_q[s];
    end

    cache_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_match (
        .way_tags(way_tags), .way_valid(valid_q[cur_set]), .tag(cur_tag),
        .hit(hit), .hit_way(hit_way));

    cache_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .q(lfsr_q));

    cache_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
        .way_valid(valid_q[cur_set]), .rnd(lfsr_q[WAY_W-1:0]), .way(vic_way));

    assign accept    = (state == S_IDLE) && cpu_req && !flush;
    assign act_go    = (accept && hit) || (state == S_REPLAY);
    assign act_we    = accept ? cpu_we    : rq_we;
    assign act_wt    = accept ? wt_mode   : rq_wt;
    assign act_wdata = accept ? cpu_wdata : rq_wdata;

    // Controller, array updates and the shared hit access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            rq_addr  <= '0;
            rq_wdata <= '0;
            rq_we    <= 1'b0;
            rq_wt    <= 1'b0;
            hit_q    <= 1'b0;
            rdata_q  <= '0;
            cnt      <= '0;
            vway     <= '0;
            vtag     <= '0;
            vdirty   <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) dirty_q[s][w] <= '0;
            end
        end else begin
            case (state)
                S_IDLE: begin
                    if (flush) begin
                        for (int s = 0; s < SETS; s++) begin
                            valid_q[s] <= '0;
                            for (int w = 0; w < WAYS; w++) dirty_q[s][w] <= '0;
                        end
                    end else if (cpu_req) begin
                        rq_addr  <= cpu_addr;
                        rq_we    <= cpu_we;
                        rq_wdata <= cpu_wdata;
                        rq_wt    <= wt_mode;
                        hit_q    <= hit;
                        cnt      <= '0;
                        if (hit) begin
                            state <= (cpu_we && wt_mode) ? S_WT : S_DONE;
                        end else begin
                            vway   <= vic_way;
                            vtag   <= tag_q[cur_set][vic_way];
                            vdirty <= dirty_q[cur_set][vic_way];
                            state  <= (|dirty_q[cur_set][vic_way]) ? S_WB : S_FILL;
                        end
                    end
                end
                S_WB: begin
                    if (!vdirty[cnt] || mem_ack) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == WORD_W'(WORDS - 1)) state <= S_FILL;
                    end
                end
                S_FILL: begin
                    if (mem_ack) begin
                        data_q[cur_set][vway][cnt] <= mem_rdata;
                        cnt <= cnt + 1'b1;
                        if (cnt == WORD_W'(WORDS - 1)) begin
                            tag_q[cur_set][vway]   <= cur_tag;
                            valid_q[cur_set][vway] <= 1'b1;
                            dirty_q[cur_set][vway] <= '0;
                            state <= S_REPLAY;
                        end
                    end
                end
                S_REPLAY: state <= (rq_we && rq_wt) ? S_WT : S_DONE;
                S_WT:     if (mem_ack) state <= S_DONE;
                default:  state <= S_IDLE;
            endcase
            if (act_go) begin
                if (act_we) begin
                    data_q[cur_set][hit_way][cur_word]  <= act_wdata;
                    dirty_q[cur_set][hit_way][cur_word] <= !act_wt;
                end else begin
                    rdata_q <= data_q[cur_set][hit_way][cur_word];
                end
            end
        end
    end

    assign cpu_ready = (state == S_DONE);
    assign cpu_hit   = hit_q;
    assign cpu_rdata = rdata_q;
    assign mem_req   = ((state == S_WB) && vdirty[cnt]) || (state == S_FILL) || (state == S_WT);
    assign mem_we    = (state == S_WB) || (state == S_WT);
    assign mem_wdata = (state == S_WB) ? data_q[cur_set][vway][cnt] : rq_wdata;

    // Memory address: victim line, new line, or the stored word.
    always_comb begin
        case (state)
            S_WB:    mem_addr = {vtag, cur_set, cnt, {BYTE_W{1'b0}}};
            S_FILL:  mem_addr = {cur_tag, cur_set, cnt, {BYTE_W{1'b0}}};
            default: mem_addr = {rq_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        endcase
    end
endmodule

// File: rtl/dcache_4way_chk.sv
// Protocol and state checks for the data cache, attached by bind.
module dcache_4way_chk
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NV     = 256,
    parameter int LW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              flush,
    input logic              cpu_ready,
    input logic              cpu_hit,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input state_t            st,
    input logic              set_hit,
    input logic [NV-1:0]     valid_flat,
    input logic [LW-1:0]     rnd
);
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r11_mem_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r2_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && cpu_req && !flush && !cpu_we && set_hit) |=> (cpu_ready && cpu_hit));

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && flush) |=> (valid_flat == '0));

    a_r8_valid_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == S_IDLE && flush) |=> (($past(valid_flat) & ~valid_flat) == '0));

    a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0);
endmodule

bind dcache_4way dcache_4way_chk #(.ADDR_W(ADDR_W), .NV(SETS*WAYS), .LW(LFSR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .flush(flush),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st(state),
    .set_hit(hit), .valid_flat(valid_flat), .rnd(lfsr_q));

// File: tb/test_dcache_4way.sv
// Bench: word memory model with random acknowledge delay, reference image of stored words,
// directed corner cases, then a seeded random mix.
module test_dcache_4way;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, wt_mode = 1'b0, flush = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_hit, mem_req, mem_we;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, fails = 0;
    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] ref_m [logic [31:0]];
    logic [32:0] ev [$];

    always #5 clk = ~clk;

    dcache_4way i_dcache_4way (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .wt_mode(wt_mode), .flush(flush), .cpu_ready(cpu_ready),
        .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

    function automatic logic [31:0] init_val(logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0F0F;
    endfunction

    function automatic logic [31:0] exp_rd(logic [31:0] a);
        logic [31:0] w = {a[31:2], 2'b00};
        return ref_m.exists(w) ? ref_m[w] : init_val(w);
    endfunction

    function automatic logic [31:0] line_addr(int tag, int set, int word);
        return (32'(tag) << 10) | (32'(set) << 4) | (32'(word) << 2);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: one acknowledge per word, at least one idle cycle between acknowledges.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && $urandom_range(0, 3) != 0) begin
                if (mem_we) mem_m[mem_addr] = mem_wdata;
                else mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : init_val(mem_addr);
                ev.push_back({mem_we, mem_addr});
                mem_ack = 1'b1;
            end
        end
    end

    task automatic acc(input logic we, input logic wt, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic hit, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; wt_mode = wt;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 3000);
        rd = cpu_rdata; hit = cpu_hit;
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) ref_m[{a[31:2], 2'b00}] = d;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    function automatic int n_writes();
        int n = 0;
        foreach (ev[i]) if (ev[i][32]) n++;
        return n;
    endfunction

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd, a, x0, y;
        logic hit;
        int lat, wr_total;
        bit found;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !mem_req, "R11 reset idle", {cpu_ready, mem_req}, 0);

        // R3: cold miss fills four words in ascending order
        a = 32'h0000_1234;
        ev.delete();
        acc(0, 0, a, 0, rd, hit, lat);
        chk(!hit, "R3 cold miss flag", hit, 0);
        chk(rd == exp_rd(a), "R3 miss data", rd, exp_rd(a));
        chk(ev.size() == 4, "R3 fill count", ev.size(), 4);
        for (int i = 0; i < 4 && i < ev.size(); i++)
            chk(ev[i] == {1'b0, 32'h0000_1230 + 32'(4 * i)}, "R3 fill order", ev[i][31:0], 32'h1230 + 32'(4 * i));

        // R2: read hit latency; R1: low address bits ignored
        acc(0, 0, a, 0, rd, hit, lat);
        chk(hit && lat == 1 && rd == exp_rd(a), "R2 hit latency", lat, 1);
        acc(0, 0, a | 32'h3, 0, rd, hit, lat);
        chk(hit && rd == exp_rd(a), "R1 byte bits ignored", rd, exp_rd(a));
        acc(0, 0, a + 32'h400, 0, rd, hit, lat);
        chk(!hit && rd == exp_rd(a + 32'h400), "R1 other tag same set misses", hit, 0);

        // R7: flush wins over a request in the same cycle
        @(negedge clk);
        flush = 1'b1; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        @(negedge clk);
        flush = 1'b0;
        lat = 0;
        while (!cpu_ready && lat < 3000) begin @(negedge clk); lat++; end
        chk(!cpu_hit && cpu_rdata == exp_rd(a), "R7 flush priority then miss", cpu_hit, 0);
        cpu_req = 1'b0;
        do_flush();
        acc(0, 0, a, 0, rd, hit, lat);
        chk(!hit, "R7 access after flush misses", hit, 0);

        // R3/R8: empty ways are used first, so four lines coexist in one set
        do_flush();
        for (int k = 1; k <= 4; k++) acc(0, 0, line_addr(k, 17, 0), 0, rd, hit, lat);
        for (int k = 1; k <= 4; k++) begin
            acc(0, 0, line_addr(k, 17, 0), 0, rd, hit, lat);
            chk(hit, "R3 invalid way preferred", hit, 1);
        end

        // R4: write-back store hit makes no memory traffic
        x0 = line_addr(1, 17, 0);
        ev.delete();
        acc(1, 0, x0 + 4, 32'hDEAD_0001, rd, hit, lat);
        acc(1, 0, x0 + 12, 32'hDEAD_0003, rd, hit, lat);
        chk(hit && ev.size() == 0, "R4 write-back hit no traffic", ev.size(), 0);
        acc(0, 0, x0 + 4, 0, rd, hit, lat);
        chk(hit && rd == 32'hDEAD_0001, "R4 stored word read back", rd, 32'hDEAD_0001);

        // R5/R9: conflict misses until the dirty line leaves; only dirty words go out, first
        found = 0; wr_total = 0;
        for (int k = 5; k < 80 && !found; k++) begin
            ev.delete();
            acc(0, 0, line_addr(k, 17, 0), 0, rd, hit, lat);
            wr_total += n_writes();
            if (n_writes() != 0) begin
                found = 1;
                chk(ev.size() == 6, "R5 eviction event count", ev.size(), 6);
                chk(ev[0] == {1'b1, x0 + 32'd4}, "R5 first dirty word", ev[0][31:0], x0 + 4);
                chk(ev[1] == {1'b1, x0 + 32'd12}, "R5 second dirty word", ev[1][31:0], x0 + 12);
                chk(!ev[2][32], "R5 writes before fill", ev[2][32], 0);
            end
        end
        chk(found, "R9 random victim reaches dirty line", found, 1);
        chk(wr_total == 2, "R5 clean lines write nothing", wr_total, 2);
        chk(mem_m[x0 + 12] == 32'hDEAD_0003, "R5 memory holds dirty word", mem_m[x0 + 12], 32'hDEAD_0003);
        acc(0, 0, x0 + 4, 0, rd, hit, lat);
        chk(!hit && rd == 32'hDEAD_0001, "R12 value after eviction", rd, 32'hDEAD_0001);

        // R6: write-through store on a miss: fill, then one write; line stays clean
        y = line_addr(100, 42, 2);
        ev.delete();
        acc(1, 1, y, 32'hBEEF_2222, rd, hit, lat);
        chk(ev.size() == 5 && ev[4] == {1'b1, y}, "R6 single write-through", ev.size(), 5);
        chk(mem_m[y] == 32'hBEEF_2222, "R6 memory updated", mem_m[y], 32'hBEEF_2222);
        acc(1, 1, y, 32'hBEEF_3333, rd, hit, lat);
        chk(hit && mem_m[y] == 32'hBEEF_3333, "R6 write-through hit", mem_m[y], 32'hBEEF_3333);
        ev.delete();
        for (int k = 101; k < 113; k++) acc(0, 0, line_addr(k, 42, 0), 0, rd, hit, lat);
        chk(n_writes() == 0, "R6 no dirty marks", n_writes(), 0);
        acc(0, 0, y, 0, rd, hit, lat);
        chk(rd == 32'hBEEF_3333, "R12 write-through value", rd, 32'hBEEF_3333);

        // R12: random mix of modes, loads and stores over a conflicting pool
        for (int n = 0; n < 600; n++) begin
            logic we, wt;
            logic [31:0] d;
            a  = line_addr($urandom_range(0, 5), 5 + $urandom_range(0, 1), $urandom_range(0, 3)) | 32'($urandom_range(0, 3));
            we = ($urandom_range(0, 2) == 0);
            wt = $urandom_range(0, 1);
            d  = $urandom;
            if (we) acc(1, wt, a, d, rd, hit, lat);
            else begin
                acc(0, wt, a, 0, rd, hit, lat);
                chk(rd == exp_rd(a), "R12 random read", rd, exp_rd(a));
                if (hit) chk(lat == 1, "R2 random hit latency", lat, 1);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule